// File: doc/BRIEF.md
# Bit-Manipulation Instruction Decoder

This block is a purely combinational decoder for the scalar bit-manipulation group of a 32-bit instruction set. It takes one instruction word plus three configuration inputs (the current base register width and two extension enables, one for general bit manipulation and one for the cryptography-oriented subset) and produces an operation select, the three register index fields, an immediate rotate amount and an illegal-instruction flag. Execution of the operations is left to the datapath that consumes the operation select.

Several encodings overlap: a pack with a zero second source register has the same bit pattern as zero-extend-halfword. The decoder resolves these overlaps through a fixed priority list. An entry that is disabled by configuration drops out of the list, and a lower-priority entry can then claim the word. Each operation is gated by an OR of the two enables, or by one enable alone, and by the base width.

Top module: `bmd_decoder`

## Requirements
- R1: `rd_o`, `rs1_o` and `rs2_o` always carry instruction bits 11:7, 19:15 and 24:20, whether the word is legal or not.
- R2: A word that matches no supported pattern, or matches only patterns disabled by configuration, drives `illegal_o` = 1 and `op_o` = 0 (no-op). A legal word drives `illegal_o` = 0.
- R3: With opcode 0110011, funct7 0100000 selects AND-NOT (funct3 111), OR-NOT (110) and XNOR (100). Funct7 0110000 selects rotate-left (funct3 001) and rotate-right (101). All five are legal on either base width when at least one enable is set.
- R4: Rotate-right-immediate uses opcode 0010011 and funct3 101, with bits 31:26 = 011000. On a 64-bit base the amount is bits 25:20. On a 32-bit base bit 25 must be 0, otherwise the word is illegal. `shamt_o` carries the amount and is 0 for every other operation.
- R5: The word-form rotates are legal only on a 64-bit base, with either enable set. Rotate-left-word and rotate-right-word use funct7 0110000, funct3 001/101 and opcode 0111011. Rotate-right-immediate-word uses bits 31:25 = 0110000, funct3 101 and opcode 0011011, with a 5-bit amount in bits 24:20.
- R6: Byte reversal has two encodings, both with funct3 101 and opcode 0010011. Bits 31:20 = 011010011000 is legal only on a 32-bit base. Bits 31:20 = 011010111000 is legal only on a 64-bit base. Each requires either enable.
- R7: Funct7 0000100, funct3 100 and opcode 0110011 with rs2 = 0 decodes as zero-extend-halfword when the general enable is set and the base is 32-bit. Otherwise the same word falls through to pack, which requires the crypto enable.
- R8: Funct7 0000100, funct3 100 and opcode 0111011 is legal only on a 64-bit base. With rs2 = 0 and the general enable set it decodes as zero-extend-halfword. Otherwise it decodes as pack-word, which requires the crypto enable.
- R9: Pack (rs2 nonzero), pack-low-bytes (funct7 0000100, funct3 111, opcode 0110011) and byte-wise bit reversal (bits 31:20 = 011010000111, funct3 101, opcode 0010011) are legal only with the crypto enable set.
- R10: Interleave (bits 31:20 = 000010001111, funct3 001, opcode 0010011) and de-interleave (same upper field, funct3 101) are legal only on a 32-bit base with the crypto enable set.
- R11: The `op_o` codes are: no-op 0, AND-NOT 1, OR-NOT 2, XNOR 3, rotate-left 4, rotate-right 5, rotate-right-immediate 6, rotate-left-word 7, rotate-right-word 8, rotate-right-immediate-word 9, byte reversal 10, zero-extend-halfword 11, byte-wise bit reversal 12, pack 13, pack-low-bytes 14, pack-word 15, interleave 16, de-interleave 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| cfg_wide_i | input | 1 | 1 = 64-bit base, 0 = 32-bit base |
| cfg_gen_en_i | input | 1 | General bit-manipulation enable |
| cfg_cry_en_i | input | 1 | Crypto bit-manipulation enable |
| op_o | output | 5 | Operation select (codes in R11) |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index (raw field) |
| shamt_o | output | 6 | Immediate rotate amount, 0 when not a rotate-immediate |
| illegal_o | output | 1 | Word not decodable under the current configuration |

## Verification
The embedded checks are immediate assertions. They assume that every input is a known 0 or 1 and that the configuration and the word settle together, because any combination of the three configuration bits is valid. The bench changes all inputs at once on the falling clock edge and holds them for a full period. Its vectors always drive all four inputs to defined values and cover each configuration class for every overlapping encoding.

// File: rtl/bmd_pkg.sv
// Shared types and the decode pattern list for the bit-manipulation decoder.
// Assumes a 32-bit instruction word. The order of PATTERNS is the decode
// priority: a lower index wins when several enabled patterns match.
package bmd_pkg;

    localparam int unsigned ILEN    = 32;
    localparam int unsigned REG_W   = 5;
    localparam int unsigned SHAMT_W = 6;
    localparam int unsigned OP_W    = 5;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 5'd0,  OP_ANDN  = 5'd1,  OP_ORN   = 5'd2,  OP_XNOR  = 5'd3,
        OP_ROL   = 5'd4,  OP_ROR   = 5'd5,  OP_RORI  = 5'd6,  OP_ROLW  = 5'd7,
        OP_RORW  = 5'd8,  OP_RORIW = 5'd9,  OP_REV8  = 5'd10, OP_ZEXTH = 5'd11,
        OP_BREV8 = 5'd12, OP_PACK  = 5'd13, OP_PACKH = 5'd14, OP_PACKW = 5'd15,
        OP_ZIP   = 5'd16, OP_UNZIP = 5'd17
    } bmd_op_e;

    typedef enum logic [1:0] {BASE_ANY, BASE_NARROW, BASE_WIDE} base_req_e;
    typedef enum logic [1:0] {EXT_EITHER, EXT_GEN, EXT_CRY} ext_req_e;

    typedef struct packed {
        logic [ILEN-1:0] mask;
        logic [ILEN-1:0] value;
        bmd_op_e         op;
        base_req_e       base;
        ext_req_e        ext;
    } pat_t;

    // Field masks: rs2 free, rs2 fixed, 6-bit top field (rs2 + bit 25 free)
    localparam logic [ILEN-1:0] M_R   = 32'hFE00_707F;
    localparam logic [ILEN-1:0] M_R2  = 32'hFFF0_707F;
    localparam logic [ILEN-1:0] M_SH6 = 32'hFC00_707F;

    localparam logic [6:0] OPC_REG  = 7'b0110011;
    localparam logic [6:0] OPC_REGW = 7'b0111011;
    localparam logic [6:0] OPC_IMM  = 7'b0010011;
    localparam logic [6:0] OPC_IMMW = 7'b0011011;

    // Build a match value from the upper 7 bits, bits 24:20, funct3 and opcode
    function automatic logic [ILEN-1:0] enc(input logic [6:0] hi7, input logic [4:0] lo5,
                                            input logic [2:0] f3, input logic [6:0] opc);
        return {hi7, lo5, 5'd0, f3, 5'd0, opc};
    endfunction

    localparam int unsigned N_PAT = 20;
    localparam int unsigned IDX_W = $clog2(N_PAT);

    localparam pat_t PATTERNS [N_PAT] = '{
        '{M_R2,  enc(7'b0000100, 5'd0,  3'b100, OPC_REG ), OP_ZEXTH, BASE_NARROW, EXT_GEN},
        '{M_R2,  enc(7'b0000100, 5'd0,  3'b100, OPC_REGW), OP_ZEXTH, BASE_WIDE,   EXT_GEN},
        '{M_R,   enc(7'b0000100, 5'd0,  3'b100, OPC_REG ), OP_PACK,  BASE_ANY,    EXT_CRY},
        '{M_R,   enc(7'b0000100, 5'd0,  3'b100, OPC_REGW), OP_PACKW, BASE_WIDE,   EXT_CRY},
        '{M_R,   enc(7'b0000100, 5'd0,  3'b111, OPC_REG ), OP_PACKH, BASE_ANY,    EXT_CRY},
        '{M_R,   enc(7'b0100000, 5'd0,  3'b111, OPC_REG ), OP_ANDN,  BASE_ANY,    EXT_EITHER},
        '{M_R,   enc(7'b0100000, 5'd0,  3'b110, OPC_REG ), OP_ORN,   BASE_ANY,    EXT_EITHER},
        '{M_R,   enc(7'b0100000, 5'd0,  3'b100, OPC_REG ), OP_XNOR,  BASE_ANY,    EXT_EITHER},
        '{M_R,   enc(7'b0110000, 5'd0,  3'b001, OPC_REG ), OP_ROL,   BASE_ANY,    EXT_EITHER},
        '{M_R,   enc(7'b0110000, 5'd0,  3'b101, OPC_REG ), OP_ROR,   BASE_ANY,    EXT_EITHER},
        '{M_R,   enc(7'b0110000, 5'd0,  3'b001, OPC_REGW), OP_ROLW,  BASE_WIDE,   EXT_EITHER},
        '{M_R,   enc(7'b0110000, 5'd0,  3'b101, OPC_REGW), OP_RORW,  BASE_WIDE,   EXT_EITHER},
        '{M_R,   enc(7'b0110000, 5'd0,  3'b101, OPC_IMM ), OP_RORI,  BASE_NARROW, EXT_EITHER},
        '{M_SH6, enc(7'b0110000, 5'd0,  3'b101, OPC_IMM ), OP_RORI,  BASE_WIDE,   EXT_EITHER},
        '{M_R,   enc(7'b0110000, 5'd0,  3'b101, OPC_IMMW), OP_RORIW, BASE_WIDE,   EXT_EITHER},
        '{M_R2,  enc(7'b0110100, 5'd24, 3'b101, OPC_IMM ), OP_REV8,  BASE_NARROW, EXT_EITHER},
        '{M_R2,  enc(7'b0110101, 5'd24, 3'b101, OPC_IMM ), OP_REV8,  BASE_WIDE,   EXT_EITHER},
        '{M_R2,  enc(7'b0110100, 5'd7,  3'b101, OPC_IMM ), OP_BREV8, BASE_ANY,    EXT_CRY},
        '{M_R2,  enc(7'b0000100, 5'd15, 3'b001, OPC_IMM ), OP_ZIP,   BASE_NARROW, EXT_CRY},
        '{M_R2,  enc(7'b0000100, 5'd15, 3'b101, OPC_IMM ), OP_UNZIP, BASE_NARROW, EXT_CRY}
    };

endpackage

// File: rtl/bmd_pattern_cell.sv
// One decode pattern: reports a hit when the word matches the pattern's
// fixed bits and the configuration permits it. Assumes PAT is a constant
// entry of bmd_pkg::PATTERNS.
module bmd_pattern_cell
    import bmd_pkg::*;
#(
    parameter pat_t PAT = '0
) (
    input  logic [ILEN-1:0] instr_i,
    input  logic            cfg_wide_i,
    input  logic            cfg_gen_en_i,
    input  logic            cfg_cry_en_i,
    output logic            hit_o
);

    logic field_ok;
    logic base_ok;
    logic ext_ok;

    // Compare the fixed bits of the word against the pattern
    always_comb field_ok = ((instr_i & PAT.mask) == PAT.value);

    // Check the base-width condition of the pattern
    always_comb begin
        case (PAT.base)
            BASE_ANY:    base_ok = 1'b1;
            BASE_NARROW: base_ok = ~cfg_wide_i;
            BASE_WIDE:   base_ok = cfg_wide_i;
            default:     base_ok = 1'b0;
        endcase
    end

    // Check the extension-enable condition of the pattern
    always_comb begin
        case (PAT.ext)
            EXT_EITHER: ext_ok = cfg_gen_en_i | cfg_cry_en_i;
            EXT_GEN:    ext_ok = cfg_gen_en_i;
            EXT_CRY:    ext_ok = cfg_cry_en_i;
            default:    ext_ok = 1'b0;
        endcase
    end

    // Combine the three conditions
    always_comb hit_o = field_ok & base_ok & ext_ok;

endmodule

// File: rtl/bmd_prio_pick.sv
// Fixed-priority picker: grants the lowest-index active request.
// Assumes index 0 carries the highest priority.
module bmd_prio_pick #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o
);

    // Walk from the lowest priority up so that the lowest index wins
    always_comb begin
        grant_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
            end
        end
    end

    // Priority resolution of overlapping encodings (R7)
    always_comb begin
        p_grant_onehot_r7: assert ($onehot0(grant_o));
        p_grant_subset_r7: assert ((grant_o & ~req_i) == '0);
        p_grant_any_r2:    assert ((|grant_o) == (|req_i));
    end

endmodule

// File: rtl/bmd_result_mux.sv
// Turns the one-hot pattern grant into an operation code and extracts the
// rotate amount. Assumes the grant is one-hot or zero.
module bmd_result_mux
    import bmd_pkg::*;
(
    input  logic [N_PAT-1:0]   grant_i,
    input  logic [5:0]         imm_hi_i,
    output logic [OP_W-1:0]    op_o,
    output logic [SHAMT_W-1:0] shamt_o
);

    // OR together the operation codes of the granted pattern
    always_comb begin
        op_o = '0;
        for (int i = 0; i < int'(N_PAT); i++) begin
            if (grant_i[i]) op_o = op_o | PATTERNS[i].op;
        end
    end

    // Select the rotate amount width by operation
    always_comb begin
        case (op_o)
            OP_RORI:  shamt_o = imm_hi_i;
            OP_RORIW: shamt_o = {1'b0, imm_hi_i[4:0]};
            default:  shamt_o = '0;
        endcase
    end

endmodule

// File: rtl/bmd_decoder.sv
// Top of the bit-manipulation decoder. Purely combinational: one pattern
// cell per entry of the pattern list, a priority picker and an output mux.
// Assumes all inputs are known and settle together; there is no state.
module bmd_decoder
    import bmd_pkg::*;
(
    input  logic [31:0] instr_i,
    input  logic        cfg_wide_i,
    input  logic        cfg_gen_en_i,
    input  logic        cfg_cry_en_i,
    output logic [4:0]  op_o,
    output logic [4:0]  rd_o,
    output logic [4:0]  rs1_o,
    output logic [4:0]  rs2_o,
    output logic [5:0]  shamt_o,
    output logic        illegal_o
);

    logic [N_PAT-1:0] hit;
    logic [N_PAT-1:0] grant;

    // One matcher per pattern entry
    for (genvar g = 0; g < int'(N_PAT); g++) begin : g_pat
        bmd_pattern_cell #(.PAT(PATTERNS[g])) u_cell (
            .instr_i      (instr_i),
            .cfg_wide_i   (cfg_wide_i),
            .cfg_gen_en_i (cfg_gen_en_i),
            .cfg_cry_en_i (cfg_cry_en_i),
            .hit_o        (hit[g])
        );
    end

    bmd_prio_pick #(.N(N_PAT)) u_pick (
        .req_i   (hit),
        .grant_o (grant)
    );

    bmd_result_mux u_mux (
        .grant_i  (grant),
        .imm_hi_i (instr_i[25:20]),
        .op_o     (op_o),
        .shamt_o  (shamt_o)
    );

    // Pass the register index fields through unchanged
    always_comb begin
        rd_o  = instr_i[11:7];
        rs1_o = instr_i[19:15];
        rs2_o = instr_i[24:20];
    end

    // Flag a word no enabled pattern claims
    always_comb illegal_o = ~|hit;

    // Output consistency against configuration
    always_comb begin
        p_illegal_nop_r2: assert (!illegal_o || op_o == OP_NOP);
        p_legal_op_r2:    assert (illegal_o || op_o != OP_NOP);
        p_shared_gate_r3: assert (illegal_o || cfg_gen_en_i || cfg_cry_en_i);
        p_shamt_rot_r4:   assert (shamt_o == '0 || op_o == OP_RORI || op_o == OP_RORIW);
        p_wide_only_r5:   assert (!(op_o == OP_ROLW || op_o == OP_RORW || op_o == OP_RORIW
                                    || op_o == OP_PACKW) || cfg_wide_i);
        p_zexth_prio_r7:  assert (op_o != OP_ZEXTH || (rs2_o == 5'd0 && cfg_gen_en_i));
        p_crypto_gate_r9: assert (!(op_o == OP_BREV8 || op_o == OP_PACK || op_o == OP_PACKH
                                    || op_o == OP_PACKW) || cfg_cry_en_i);
        p_narrow_only_r10: assert (!(op_o == OP_ZIP || op_o == OP_UNZIP)
                                   || (!cfg_wide_i && cfg_cry_en_i));
    end

endmodule

// File: tb/bmd_decoder_bench.sv
module bmd_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic        c_wide = 1'b0, c_gen = 1'b0, c_cry = 1'b0;
    logic [4:0]  op, rd, rs1, rs2;
    logic [5:0]  shamt;
    logic        ill;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    bmd_decoder u_bmd_decoder (
        .instr_i (instr), .cfg_wide_i (c_wide), .cfg_gen_en_i (c_gen), .cfg_cry_en_i (c_cry),
        .op_o (op), .rd_o (rd), .rs1_o (rs1), .rs2_o (rs2), .shamt_o (shamt), .illegal_o (ill)
    );

    localparam logic [6:0] REG = 7'b0110011, REGW = 7'b0111011;
    localparam logic [6:0] IMM = 7'b0010011, IMMW = 7'b0011011;

    function automatic logic [31:0] mkr(input logic [6:0] f7, input logic [4:0] r2,
                                        input logic [4:0] r1, input logic [2:0] f3,
                                        input logic [4:0] d, input logic [6:0] opc);
        return {f7, r2, r1, f3, d, opc};
    endfunction

    typedef struct packed {
        logic [31:0] instr;
        logic [2:0]  cfg;   // {wide, gen, cry}
        logic [4:0]  op;
        logic        ill;
        logic [5:0]  sh;
        logic [7:0]  req;
    } vec_t;

    localparam int N_VEC = 38;
    localparam vec_t VEC [N_VEC] = '{
        '{mkr(7'b0100000, 5'd3,  5'd9, 3'b111, 5'd6, REG),  3'b010, 5'd1,  1'b0, 6'd0,  8'd3},  // R3 andn
        '{mkr(7'b0100000, 5'd3,  5'd9, 3'b110, 5'd6, REG),  3'b101, 5'd2,  1'b0, 6'd0,  8'd3},  // R3 orn
        '{mkr(7'b0100000, 5'd3,  5'd9, 3'b100, 5'd6, REG),  3'b000, 5'd0,  1'b1, 6'd0,  8'd2},  // R2 none enabled
        '{mkr(7'b0100000, 5'd3,  5'd9, 3'b100, 5'd6, REG),  3'b011, 5'd3,  1'b0, 6'd0,  8'd3},  // R3 xnor
        '{mkr(7'b0110000, 5'd3,  5'd9, 3'b001, 5'd6, REG),  3'b001, 5'd4,  1'b0, 6'd0,  8'd3},  // R3 rol
        '{mkr(7'b0110000, 5'd3,  5'd9, 3'b101, 5'd6, REG),  3'b110, 5'd5,  1'b0, 6'd0,  8'd3},  // R3 ror
        '{mkr(7'b0110000, 5'd31, 5'd9, 3'b101, 5'd6, IMM),  3'b010, 5'd6,  1'b0, 6'd31, 8'd4},  // R4 rori narrow
        '{mkr(7'b0110001, 5'd4,  5'd9, 3'b101, 5'd6, IMM),  3'b011, 5'd0,  1'b1, 6'd0,  8'd4},  // R4 bit25 narrow
        '{mkr(7'b0110001, 5'd13, 5'd9, 3'b101, 5'd6, IMM),  3'b110, 5'd6,  1'b0, 6'd45, 8'd4},  // R4 rori wide
        '{mkr(7'b0110000, 5'd3,  5'd9, 3'b001, 5'd6, REGW), 3'b101, 5'd7,  1'b0, 6'd0,  8'd5},  // R5 rolw
        '{mkr(7'b0110000, 5'd3,  5'd9, 3'b001, 5'd6, REGW), 3'b011, 5'd0,  1'b1, 6'd0,  8'd5},  // R5 rolw narrow
        '{mkr(7'b0110000, 5'd3,  5'd9, 3'b101, 5'd6, REGW), 3'b110, 5'd8,  1'b0, 6'd0,  8'd5},  // R5 rorw
        '{mkr(7'b0110000, 5'd17, 5'd9, 3'b101, 5'd6, IMMW), 3'b110, 5'd9,  1'b0, 6'd17, 8'd5},  // R5 roriw
        '{mkr(7'b0110001, 5'd17, 5'd9, 3'b101, 5'd6, IMMW), 3'b111, 5'd0,  1'b1, 6'd0,  8'd5},  // R5 roriw bit25
        '{mkr(7'b0110000, 5'd17, 5'd9, 3'b101, 5'd6, IMMW), 3'b011, 5'd0,  1'b1, 6'd0,  8'd5},  // R5 roriw narrow
        '{mkr(7'b0110100, 5'd24, 5'd9, 3'b101, 5'd6, IMM),  3'b001, 5'd10, 1'b0, 6'd0,  8'd6},  // R6 rev8 32-form
        '{mkr(7'b0110100, 5'd24, 5'd9, 3'b101, 5'd6, IMM),  3'b111, 5'd0,  1'b1, 6'd0,  8'd6},  // R6 32-form on wide
        '{mkr(7'b0110101, 5'd24, 5'd9, 3'b101, 5'd6, IMM),  3'b110, 5'd10, 1'b0, 6'd0,  8'd6},  // R6 rev8 64-form
        '{mkr(7'b0110101, 5'd24, 5'd9, 3'b101, 5'd6, IMM),  3'b011, 5'd0,  1'b1, 6'd0,  8'd6},  // R6 64-form narrow
        '{mkr(7'b0000100, 5'd0,  5'd9, 3'b100, 5'd6, REG),  3'b010, 5'd11, 1'b0, 6'd0,  8'd7},  // R7 zexth
        '{mkr(7'b0000100, 5'd0,  5'd9, 3'b100, 5'd6, REG),  3'b001, 5'd13, 1'b0, 6'd0,  8'd7},  // R7 falls to pack
        '{mkr(7'b0000100, 5'd0,  5'd9, 3'b100, 5'd6, REG),  3'b011, 5'd11, 1'b0, 6'd0,  8'd7},  // R7 zexth wins
        '{mkr(7'b0000100, 5'd0,  5'd9, 3'b100, 5'd6, REG),  3'b111, 5'd13, 1'b0, 6'd0,  8'd7},  // R7 wide -> pack
        '{mkr(7'b0000100, 5'd5,  5'd9, 3'b100, 5'd6, REG),  3'b011, 5'd13, 1'b0, 6'd0,  8'd9},  // R9 pack
        '{mkr(7'b0000100, 5'd5,  5'd9, 3'b100, 5'd6, REG),  3'b010, 5'd0,  1'b1, 6'd0,  8'd9},  // R9 pack no crypto
        '{mkr(7'b0000100, 5'd0,  5'd9, 3'b100, 5'd6, REGW), 3'b110, 5'd11, 1'b0, 6'd0,  8'd8},  // R8 zexth word
        '{mkr(7'b0000100, 5'd0,  5'd9, 3'b100, 5'd6, REGW), 3'b101, 5'd15, 1'b0, 6'd0,  8'd8},  // R8 falls to packw
        '{mkr(7'b0000100, 5'd5,  5'd9, 3'b100, 5'd6, REGW), 3'b111, 5'd15, 1'b0, 6'd0,  8'd8},  // R8 packw
        '{mkr(7'b0000100, 5'd5,  5'd9, 3'b100, 5'd6, REGW), 3'b011, 5'd0,  1'b1, 6'd0,  8'd8},  // R8 packw narrow
        '{mkr(7'b0000100, 5'd5,  5'd9, 3'b111, 5'd6, REG),  3'b001, 5'd14, 1'b0, 6'd0,  8'd9},  // R9 packh
        '{mkr(7'b0000100, 5'd5,  5'd9, 3'b111, 5'd6, REG),  3'b110, 5'd0,  1'b1, 6'd0,  8'd9},  // R9 packh no crypto
        '{mkr(7'b0110100, 5'd7,  5'd9, 3'b101, 5'd6, IMM),  3'b101, 5'd12, 1'b0, 6'd0,  8'd9},  // R9 brev8
        '{mkr(7'b0110100, 5'd7,  5'd9, 3'b101, 5'd6, IMM),  3'b110, 5'd0,  1'b1, 6'd0,  8'd9},  // R9 brev8 no crypto
        '{mkr(7'b0000100, 5'd15, 5'd9, 3'b001, 5'd6, IMM),  3'b001, 5'd16, 1'b0, 6'd0,  8'd10}, // R10 zip
        '{mkr(7'b0000100, 5'd15, 5'd9, 3'b101, 5'd6, IMM),  3'b011, 5'd17, 1'b0, 6'd0,  8'd10}, // R10 unzip
        '{mkr(7'b0000100, 5'd15, 5'd9, 3'b001, 5'd6, IMM),  3'b101, 5'd0,  1'b1, 6'd0,  8'd10}, // R10 zip wide
        '{32'h0000_0000,                                    3'b111, 5'd0,  1'b1, 6'd0,  8'd2},  // R2 zero word
        '{mkr(7'b0000000, 5'd0,  5'd9, 3'b000, 5'd6, IMM),  3'b111, 5'd0,  1'b1, 6'd0,  8'd2}   // R2 base op
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w, input logic [2:0] cfg);
        @(negedge clk);
        instr = w;
        {c_wide, c_gen, c_cry} = cfg;
        #1;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        // Reset-time state: an all-zero word is illegal (R2)
        chk("R2", "reset illegal", 32'(ill), 32'd1);
        chk("R2", "reset op", 32'(op), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < N_VEC; i++) begin
            string tag;
            apply(VEC[i].instr, VEC[i].cfg);
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            chk(tag, "op", 32'(op), 32'(VEC[i].op));
            chk(tag, "illegal", 32'(ill), 32'(VEC[i].ill));
            chk($sformatf("R4 vec%0d", i), "shamt", 32'(shamt), 32'(VEC[i].sh));
        end

        // R1: index fields on a legal word
        apply(mkr(7'b0100000, 5'd31, 5'd17, 3'b111, 5'd9, REG), 3'b010);
        chk("R1", "rd", 32'(rd), 32'd9);
        chk("R1", "rs1", 32'(rs1), 32'd17);
        chk("R1", "rs2", 32'(rs2), 32'd31);
        // R1: index fields on an illegal all-ones word
        apply(32'hFFFF_FFFF, 3'b111);
        chk("R1", "rd illegal", 32'(rd), 32'd31);
        chk("R1", "rs1 illegal", 32'(rs1), 32'd31);
        chk("R1", "rs2 illegal", 32'(rs2), 32'd31);
        chk("R2", "all-ones op", 32'(op), 32'd0);
        chk("R2", "all-ones illegal", 32'(ill), 32'd1);
        // R11: rotate-immediate in wide mode with largest amount
        apply(mkr(7'b0110001, 5'd31, 5'd1, 3'b101, 5'd2, IMM), 3'b101);
        chk("R11", "rori code", 32'(op), 32'd6);
        chk("R4", "max shamt", 32'(shamt), 32'd63);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule